// File: doc/BRIEF.md
# Peripheral Clock Prescaler and Gating

This block turns one selected peripheral source clock into the enable strobes that drive timers, serial channels, the analog converter and two CAN controllers. Every clock is an enable strobe on one fast reference clock `clk`. A source edge is a cycle with `src_tick` high. A sub-clock edge is a cycle with `sub_tick` high. The timer set and the serial set are separate prescalers built the same way. Each has taps at divide-by-1, 2, 8 and 32. The converter gets the source undivided. Each CAN strobe has its own divide ratio, chosen from 1, 2, 4, 8 and 16.

The whole divided group stops while the core waits with peripheral-stop-in-wait set, or while the chip is in low-power state. A sleeping CAN controller sees its clock parked high. The sub-clock timer strobe passes straight through whenever the sub oscillator runs. The wait and low-power gates do not affect it. A clock-output pin shows a square wave. The wave toggles on each strobe of the chosen clock.

Top module: `pclk_gen`

## Requirements
- R1: Bits 0..3 of `tmr_en` pulse on source edges 1, 2, 8 and 32 (every Nth ungated edge, counting from reset). Each pulse appears on the cycle after the source edge.
- R2: `sio_en` follows the same tap rule as `tmr_en` on its own counter. Under identical inputs it equals `tmr_en` on every cycle.
- R3: `adc_en` is high on the cycle after each ungated source edge.
- R4: CAN ratio code 000/001/010/011/100 divides by 1/2/4/8/16. Each CAN counter advances only on ungated edges while that channel is awake.
- R5: CAN ratio codes 101, 110 and 111 divide by 16.
- R6: While `wait_mode` and `stop_in_wait` are both 1, the timer, serial, converter and CAN strobes are 0. With `stop_in_wait` at 0, waiting has no effect.
- R7: While `low_power` is 1, the timer, serial, converter and CAN strobes are 0.
- R8: While `can_sleep[i]` is 1, `can_en[i]` is 0 and `can_parked[i]` is 1 on the next cycle. Otherwise `can_parked[i]` is 0.
- R9: `sub_tmr_en` is high on the cycle after `sub_tick` when `sub_running` is 1. It ignores the wait and low-power gates.
- R10: In single-chip mode, `cko_sel` 00 drives `clk_out` low. Code 01 toggles the pin on each sub-timer strobe, 10 on each f8 (tap 2) strobe and 11 on each f32 (tap 3) strobe.
- R11: With `single_chip` at 0, `clk_out` is low on the next cycle.
- R12: Prescaler counters hold their count while gated. The first pulse after the gate lifts keeps the full period.
- R13: Synchronous reset clears every counter and every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 1 | Edge strobe of the selected peripheral source |
| sub_tick | input | 1 | Edge strobe of the sub oscillator |
| sub_running | input | 1 | Sub oscillator active |
| wait_mode | input | 1 | Core is in wait state |
| stop_in_wait | input | 1 | Stop peripheral clocks while waiting |
| low_power | input | 1 | Low-power dissipation state |
| can_sleep | input | 2 | Per-channel CAN sleep |
| can_ratio | input | 6 | Ratio code: bits [2:0] for CAN0, [5:3] for CAN1 |
| single_chip | input | 1 | Single-chip operating mode |
| cko_sel | input | 2 | Clock-output source select |
| tmr_en | output | 4 | Timer strobes (divide by 1, 2, 8, 32) |
| sio_en | output | 4 | Serial strobes (divide by 1, 2, 8, 32) |
| adc_en | output | 1 | Converter strobe |
| can_en | output | 2 | CAN strobes |
| can_parked | output | 2 | CAN clock held high |
| sub_tmr_en | output | 1 | Sub-clock timer strobe |
| clk_out | output | 1 | Clock-output pin level |

## Verification
Every output is registered. A result is due exactly one reference cycle after the input cycle that causes it. This holds for strobes, the parked flags, the pin toggle and the forced-low pin. The bench drives inputs on falling edges. A behavioural model runs on each rising edge and reads the same inputs the design samples. It predicts what the registers will hold after that edge. The bench compares the predictions with the outputs on the next falling edge. Held counts, ratio changes and gate transitions therefore line up with the design's one-cycle latency.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

  typedef enum logic [1:0] {
    CKO_OFF = 2'b00,
    CKO_SUB = 2'b01,
    CKO_F8  = 2'b10,
    CKO_F32 = 2'b11
  } cko_sel_e;

  // Clamp a CAN ratio code to a shift amount; out-of-range codes use the maximum.
  function automatic int unsigned ratio_shift(input logic [2:0] code, input int unsigned max_sh);
    int unsigned c;
    c = int'(code);
    return (c > max_sh) ? max_sh : c;
  endfunction

endpackage

// File: rtl/pclk_div_bank.sv
module pclk_div_bank #(
  parameter int NTAP   = 4,
  parameter int MAXSH  = 5,
  parameter logic [NTAP*8-1:0] TAP_SH_V = {8'd5, 8'd3, 8'd1, 8'd0}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  output logic [NTAP-1:0] stb_now,
  output logic [NTAP-1:0] stb_o
);

  logic [MAXSH-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      stb_o <= '0;
    end else begin
      if (adv) cnt <= cnt + 1'b1;
      stb_o <= stb_now;
    end
  end

  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    localparam int SH = int'(TAP_SH_V[t*8 +: 8]);
    if (SH == 0) begin : g_full
      assign stb_now[t] = adv;
    end else begin : g_div
      assign stb_now[t] = adv & (&cnt[SH-1:0]);
    end
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt)) else $error("bank count moved while gated"); // R12

  AST_TAP_NESTED: assert property (@(posedge clk) disable iff (rst)
    stb_o[NTAP-1] |-> stb_o[0]) else $error("slow tap without base tick"); // R1

endmodule

// File: rtl/pclk_can_div.sv
module pclk_can_div #(
  parameter int MAX_LOG2 = 4,
  parameter int CODE_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              sleep,
  input  logic [CODE_W-1:0] code,
  output logic              stb_o,
  output logic              park_o
);
  import pclk_pkg::*;

  logic [MAX_LOG2-1:0] cnt;
  logic [MAX_LOG2:0]   mask_w;
  logic [MAX_LOG2-1:0] mask;
  logic                run;
  logic                hit;

  always_comb begin
    mask_w = (({{MAX_LOG2{1'b0}}, 1'b1}) << ratio_shift(code, MAX_LOG2)) - 1'b1;
    mask   = mask_w[MAX_LOG2-1:0];
    run    = adv & ~sleep;
    hit    = run & ((cnt & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      stb_o  <= 1'b0;
      park_o <= 1'b0;
    end else begin
      if (run) cnt <= cnt + 1'b1;
      stb_o  <= hit;
      park_o <= sleep;
    end
  end

  AST_CAN_PARK: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (park_o && !stb_o)) else $error("CAN clock not parked"); // R8

  AST_CAN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt)) else $error("CAN count moved while gated"); // R12

endmodule

// File: rtl/pclk_cko.sv
module pclk_cko (
  input  logic       clk,
  input  logic       rst,
  input  logic       single_chip,
  input  logic [1:0] sel,
  input  logic       sub_stb,
  input  logic       f8_stb,
  input  logic       f32_stb,
  output logic       pin
);
  import pclk_pkg::*;

  cko_sel_e sel_e;
  logic     pick;

  always_comb begin
    sel_e = cko_sel_e'(sel);
    unique case (sel_e)
      CKO_SUB: pick = sub_stb;
      CKO_F8:  pick = f8_stb;
      CKO_F32: pick = f32_stb;
      default: pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                                 pin <= 1'b0;
    else if (!single_chip || sel_e == CKO_OFF) pin <= 1'b0;
    else if (pick)                           pin <= ~pin;
  end

  AST_CKO_LOW: assert property (@(posedge clk) disable iff (rst)
    !single_chip |=> !pin) else $error("clock pin active outside single-chip"); // R11

  AST_CKO_STILL: assert property (@(posedge clk) disable iff (rst)
    (single_chip && sel != 2'b00 && !pick) |=> $stable(pin)) else $error("pin moved without strobe"); // R10

endmodule

// File: rtl/pclk_gen.sv
module pclk_gen #(
  parameter int NUM_CAN  = 2,
  parameter int CAN_W    = 3,
  parameter int CAN_MAXL = 4,
  parameter int NTAP     = 4,
  parameter int MAXSH    = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     src_tick,
  input  logic                     sub_tick,
  input  logic                     sub_running,
  input  logic                     wait_mode,
  input  logic                     stop_in_wait,
  input  logic                     low_power,
  input  logic [NUM_CAN-1:0]       can_sleep,
  input  logic [NUM_CAN*CAN_W-1:0] can_ratio,
  input  logic                     single_chip,
  input  logic [1:0]               cko_sel,
  output logic [NTAP-1:0]          tmr_en,
  output logic [NTAP-1:0]          sio_en,
  output logic                     adc_en,
  output logic [NUM_CAN-1:0]       can_en,
  output logic [NUM_CAN-1:0]       can_parked,
  output logic                     sub_tmr_en,
  output logic                     clk_out
);

  localparam int NSET = 2;
  localparam logic [NTAP*8-1:0] TAPS = {8'd5, 8'd3, 8'd1, 8'd0};

  logic gate_wait;
  logic gate;
  logic adv;
  logic sub_now;
  logic [NTAP-1:0] set_now [NSET];
  logic [NTAP-1:0] set_q   [NSET];

  assign gate_wait = wait_mode & stop_in_wait;
  assign gate      = gate_wait | low_power;
  assign adv       = src_tick & ~gate;
  assign sub_now   = sub_tick & sub_running;

  for (genvar s = 0; s < NSET; s++) begin : g_set
    pclk_div_bank #(.NTAP(NTAP), .MAXSH(MAXSH), .TAP_SH_V(TAPS)) u_bank (
      .clk(clk), .rst(rst), .adv(adv),
      .stb_now(set_now[s]), .stb_o(set_q[s]));
  end
  assign tmr_en = set_q[0];
  assign sio_en = set_q[1];

  for (genvar c = 0; c < NUM_CAN; c++) begin : g_can
    pclk_can_div #(.MAX_LOG2(CAN_MAXL), .CODE_W(CAN_W)) u_can (
      .clk(clk), .rst(rst), .adv(adv), .sleep(can_sleep[c]),
      .code(can_ratio[c*CAN_W +: CAN_W]),
      .stb_o(can_en[c]), .park_o(can_parked[c]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      adc_en     <= 1'b0;
      sub_tmr_en <= 1'b0;
    end else begin
      adc_en     <= adv;
      sub_tmr_en <= sub_now;
    end
  end

  pclk_cko u_cko (
    .clk(clk), .rst(rst), .single_chip(single_chip), .sel(cko_sel),
    .sub_stb(sub_now), .f8_stb(set_now[0][2]), .f32_stb(set_now[0][3]),
    .pin(clk_out));

  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    gate_wait |=> (tmr_en == '0 && sio_en == '0 && !adc_en && can_en == '0)) else $error("strobe in wait"); // R6

  AST_LP_QUIET: assert property (@(posedge clk) disable iff (rst)
    low_power |=> (tmr_en == '0 && sio_en == '0 && !adc_en && can_en == '0)) else $error("strobe in low power"); // R7

  AST_ADC_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (src_tick && !wait_mode && !low_power) |=> adc_en) else $error("converter strobe missing"); // R3

  AST_SUB_PASS: assert property (@(posedge clk) disable iff (rst)
    (sub_tick && sub_running) |=> sub_tmr_en) else $error("sub strobe missing"); // R9

  AST_SETS_MATCH: assert property (@(posedge clk) disable iff (rst)
    tmr_en == sio_en) else $error("timer and serial sets diverged"); // R2

endmodule

// File: tb/pclk_gen_tb.sv
module pclk_gen_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic src_tick = 0, sub_tick = 0, sub_running = 0;
  logic wait_mode = 0, stop_in_wait = 0, low_power = 0;
  logic [1:0] can_sleep = 0;
  logic [5:0] can_ratio = 0;
  logic single_chip = 0;
  logic [1:0] cko_sel = 0;
  logic [3:0] tmr_en, sio_en;
  logic adc_en, sub_tmr_en, clk_out;
  logic [1:0] can_en, can_parked;

  always #5 clk = ~clk;

  pclk_gen u_dut (
    .clk(clk), .rst(rst), .src_tick(src_tick), .sub_tick(sub_tick),
    .sub_running(sub_running), .wait_mode(wait_mode), .stop_in_wait(stop_in_wait),
    .low_power(low_power), .can_sleep(can_sleep), .can_ratio(can_ratio),
    .single_chip(single_chip), .cko_sel(cko_sel), .tmr_en(tmr_en), .sio_en(sio_en),
    .adc_en(adc_en), .can_en(can_en), .can_parked(can_parked),
    .sub_tmr_en(sub_tmr_en), .clk_out(clk_out));

  int checks = 0, fails = 0;
  string tag = "R13";
  int src_period = 1, sub_period = 0, ncyc = 0;
  bit done = 0;

  // reference model state
  int tcnt = 0, scnt = 0;
  int ccnt [2] = '{0, 0};
  bit [3:0] e_tmr = 0, e_sio = 0;
  bit e_adc = 0, e_sub = 0, e_pin = 0;
  bit [1:0] e_can = 0, e_park = 0;

  function automatic bit [3:0] taps(int c, bit a);
    bit [3:0] r;
    r[0] = a;
    r[1] = a && (c % 2 == 1);
    r[2] = a && (c % 8 == 7);
    r[3] = a && (c % 32 == 31);
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      tcnt = 0; scnt = 0; ccnt[0] = 0; ccnt[1] = 0;
      e_tmr = 0; e_sio = 0; e_adc = 0; e_sub = 0; e_pin = 0; e_can = 0; e_park = 0;
    end else begin
      bit gated, a, sb;
      int code, dv;
      gated = (wait_mode && stop_in_wait) || low_power;
      a = src_tick && !gated;
      e_tmr = taps(tcnt, a);
      e_sio = taps(scnt, a);
      if (a) begin tcnt = (tcnt + 1) % 32; scnt = (scnt + 1) % 32; end
      e_adc = a;
      for (int i = 0; i < 2; i++) begin
        code = int'(can_ratio[i*3 +: 3]);
        dv = (code >= 4) ? 16 : (1 << code);
        e_can[i] = a && !can_sleep[i] && (ccnt[i] % dv == dv - 1);
        if (a && !can_sleep[i]) ccnt[i] = (ccnt[i] + 1) % 16;
        e_park[i] = can_sleep[i];
      end
      e_sub = sub_tick && sub_running;
      case (cko_sel)
        2'b01: sb = e_sub;
        2'b10: sb = e_tmr[2];
        2'b11: sb = e_tmr[3];
        default: sb = 0;
      endcase
      if (!single_chip || cko_sel == 2'b00) e_pin = 0;
      else if (sb) e_pin = !e_pin;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("tmr_en", tmr_en, e_tmr);
    chk("sio_en", sio_en, e_sio);
    chk("adc_en", adc_en, e_adc);
    chk("can_en", can_en, e_can);
    chk("can_parked", can_parked, e_park);
    chk("sub_tmr_en", sub_tmr_en, e_sub);
    chk("clk_out", clk_out, e_pin);
  end

  // input pattern generator (falling edge)
  always @(negedge clk) begin
    ncyc++;
    src_tick <= (src_period == 0) ? 1'($urandom_range(0, 1)) : (ncyc % src_period == 0);
    sub_tick <= (sub_period == 0) ? 1'b0 : (ncyc % sub_period == 0);
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tag = "R13"; rst = 1; run(4);
    rst = 0;
    tag = "R1"; single_chip = 1; cko_sel = 2'b10; can_ratio = {3'd1, 3'd0}; run(80);
    tag = "R2"; src_period = 3; run(100);
    tag = "R3"; src_period = 2; run(40);
    tag = "R4"; can_ratio = {3'd4, 3'd3}; cko_sel = 2'b11; src_period = 1; run(100);
    can_ratio = {3'd2, 3'd1}; run(40);
    tag = "R5"; can_ratio = {3'd7, 3'd5}; run(70); can_ratio = {3'd6, 3'd6}; run(40);
    tag = "R10"; sub_running = 1; sub_period = 5; cko_sel = 2'b01; run(60);
    cko_sel = 2'b00; run(20); cko_sel = 2'b10; run(40);
    tag = "R6"; wait_mode = 1; stop_in_wait = 1; run(37);
    stop_in_wait = 0; run(30); wait_mode = 0;
    tag = "R9"; wait_mode = 1; stop_in_wait = 1; low_power = 1; run(30);
    sub_running = 0; run(20); sub_running = 1;
    tag = "R7"; wait_mode = 0; stop_in_wait = 0; run(25);
    tag = "R12"; low_power = 0; run(70);
    tag = "R8"; can_sleep = 2'b01; run(30); can_sleep = 2'b11; run(20); can_sleep = 2'b00; run(30);
    tag = "R11"; single_chip = 0; run(30); single_chip = 1; cko_sel = 2'b11; run(70);
    tag = "R13"; rst = 1; run(3); rst = 0; run(20);
    tag = "R4"; src_period = 0; sub_period = 3;
    for (int k = 0; k < 40; k++) begin
      can_ratio = 6'($urandom); can_sleep = 2'($urandom); cko_sel = 2'($urandom);
      wait_mode = 1'($urandom); stop_in_wait = 1'($urandom);
      low_power = ($urandom_range(0, 7) == 0); single_chip = ($urandom_range(0, 5) != 0);
      sub_running = ($urandom_range(0, 3) != 0);
      run(50);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule